// File: doc/BRIEF.md
# Destination-Address Receive Filter

This block decides, for each incoming frame, whether the destination MAC address is wanted and which receive queue should take the frame. A lookup starts when the receive path presents a 48-bit destination address together with a one-cycle strobe. One clock later the filter returns a registered verdict: a valid pulse, an accept flag and a 3-bit queue number.

The filter holds the station address and three byte-entry tables. Every table entry uses the same layout: an accept bit and a queue field. Unicast frames must match the station address in everything above the low nibble, and that nibble then selects one of 16 unicast entries. Multicast frames in the reserved 01-00-5E-00-00-xx range index a 256-entry special table directly by the last byte. All other multicast frames, broadcast included, index a 256-entry general table through an 8-bit CRC hash of the address.

Software programs the tables through a word-wide write port with byte enables, so one entry can be changed without disturbing its three neighbours. Values read back through a registered read port. A two-state machine sequences the result: it goes from ST_IDLE to ST_RESULT on a strobe (transition LOOKUP), stays in ST_RESULT while strobes keep arriving (transition CHAIN), and returns to ST_IDLE after a cycle with no strobe (transition DRAIN). The result is valid exactly while the machine is in ST_RESULT.

Top module: `dafilt_top`

## Requirements
- R1: After reset every table entry, the station address and all result outputs are zero, so any lookup is rejected.
- R2: Word addresses are: station-high 0x00, station-low 0x01, unicast 0x04..0x07, special 0x40..0x7F, general 0x80..0xBF. A write changes only the byte lanes whose `wr_be` bit is set. `rd_data` shows the word at `rd_addr` one clock later.
- R3: Station byte 0 (the first byte on the wire, `da[47:40]`) sits in station-high bits 31:24, and bytes 1..3 follow downward. Bytes 4..5 sit in station-low bits 15:0, and station-low bits 31:16 always read as zero.
- R4: The unicast entry for nibble n is in word 0x04 + n/4, in lane n%4 (bits 8*(n%4)+7 : 8*(n%4)). The special and general entries for index k are in word base + k/4, in lane k%4.
- R5: In every entry, bit 0 is the accept bit and bits 3:1 are the queue number.
- R6: A frame with `da[40]` clear is accepted only if `da[47:4]` equals the station address bits 47:4 and the entry selected by `da[3:0]` has its accept bit set.
- R7: A frame with `da[40]` set and `da[47:8]` = 0x01005E0000 uses the special entry indexed by `da[7:0]`.
- R8: Any other frame with `da[40]` set uses the general entry indexed by CRC-8 (polynomial 0x07, initial value 0, no final inversion) over `da[47]` down to `da[0]`, processed most significant bit first.
- R9: `res_valid` is high exactly in the cycle after each cycle in which `da_valid` is high, including back-to-back strobes. While `res_valid` is low, `res_accept` and `res_queue` are zero.
- R10: When a result is rejected, `res_queue` is zero.
- R11: A write in the same cycle as a lookup does not affect that lookup; it affects the next one.
- R12: A write to an address outside the map of R2 changes nothing, and a read of such an address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register word address for the write |
| wr_data | input | 32 | Register write data |
| wr_be | input | 4 | Byte-lane enables for the write |
| rd_addr | input | 8 | Register word address for the read |
| rd_data | output | 32 | Registered read data |
| da_valid | input | 1 | Destination address strobe |
| da | input | 48 | Destination MAC address, first wire byte in bits 47:40 |
| res_valid | output | 1 | Verdict valid, one cycle after the strobe |
| res_accept | output | 1 | Frame accepted |
| res_queue | output | 3 | Receive queue of an accepted frame |

## Verification
The bench programs a single unicast entry and then probes the neighbouring nibble and an address that differs only above the nibble. A filter that ignored the upper station bits, or picked the wrong lane, would accept one of those probes. A byte-enable write beside a live entry must leave that entry intact; a full-word write would erase it. Special-range and hashed multicast addresses are programmed in their computed lanes, so a wrong prefix test or a different CRC bit order makes the programmed address miss. A write issued in the same cycle as a lookup must not change that lookup's verdict, and back-to-back strobes must each yield one result in order.

// File: rtl/dafilt_pkg.sv
package dafilt_pkg;

    localparam int MAC_W = 48;
    localparam int REG_W = 32;
    localparam int HASH_W = 8;

    localparam int ADR_MAC_HI = 'h00;
    localparam int ADR_MAC_LO = 'h01;
    localparam int ADR_UC_BASE = 'h04;
    localparam int ADR_SM_BASE = 'h40;
    localparam int ADR_OM_BASE = 'h80;

    localparam logic [MAC_W-1:0] SPECIAL_BASE = 48'h01005E000000;

    typedef enum logic [1:0] {
        CLS_UNICAST,
        CLS_SPECIAL,
        CLS_OTHER
    } da_class_e;

    typedef enum logic {
        ST_IDLE,
        ST_RESULT
    } res_state_e;

    // Serial CRC-8, polynomial x^8+x^2+x+1, most significant address bit first.
    function automatic logic [HASH_W-1:0] addr_hash(input logic [MAC_W-1:0] a);
        logic [HASH_W-1:0] c;
        logic fb;
        c = '0;
        for (int i = MAC_W - 1; i >= 0; i--) begin
            fb = c[HASH_W-1] ^ a[i];
            c  = {c[HASH_W-2:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
        end
        return c;
    endfunction

endpackage

// File: rtl/dafilt_word.sv
module dafilt_word #(
    parameter int W = 32,
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] ADR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic [W/8-1:0]    wr_be,
    output logic [W-1:0]      q
);
    localparam int LANES = W / 8;

    logic hit;
    assign hit = wr_en && (wr_addr == ADR);

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                q[8*b +: 8] <= '0;
            end else if (hit && wr_be[b]) begin
                q[8*b +: 8] <= wr_data[8*b +: 8];
            end
        end
    end
endmodule

// File: rtl/dafilt_regs.sv
module dafilt_regs
    import dafilt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int UC_WORDS = 4,
    parameter int MC_WORDS = 64,
    localparam int UCW_W = $clog2(UC_WORDS),
    localparam int MCW_W = $clog2(MC_WORDS),
    localparam int UCI_W = UCW_W + 2,
    localparam int MCI_W = MCW_W + 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [REG_W-1:0]       wr_data,
    input  logic [3:0]             wr_be,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [REG_W-1:0]       rd_data,
    input  logic [UCI_W-1:0]       uc_idx,
    input  logic [MCI_W-1:0]       sm_idx,
    input  logic [MCI_W-1:0]       om_idx,
    output logic [3:0]             uc_entry,
    output logic [3:0]             sm_entry,
    output logic [3:0]             om_entry,
    output logic [MAC_W-UCI_W-1:0] mac_upper
);
    localparam logic [ADDR_W-1:0] MAC_HI_A = ADDR_W'(ADR_MAC_HI);
    localparam logic [ADDR_W-1:0] MAC_LO_A = ADDR_W'(ADR_MAC_LO);
    localparam logic [ADDR_W-UCW_W-1:0] UC_TAG = (ADDR_W-UCW_W)'(ADR_UC_BASE >> UCW_W);
    localparam logic [ADDR_W-MCW_W-1:0] SM_TAG = (ADDR_W-MCW_W)'(ADR_SM_BASE >> MCW_W);
    localparam logic [ADDR_W-MCW_W-1:0] OM_TAG = (ADDR_W-MCW_W)'(ADR_OM_BASE >> MCW_W);

    logic [REG_W-1:0] mac_hi_q;
    logic [15:0]      mac_lo_q;
    logic [REG_W-1:0] uc_w [UC_WORDS];
    logic [REG_W-1:0] sm_w [MC_WORDS];
    logic [REG_W-1:0] om_w [MC_WORDS];

    dafilt_word #(.W(REG_W), .ADDR_W(ADDR_W), .ADR(MAC_HI_A)) u_mac_hi (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_be(wr_be), .q(mac_hi_q)
    );

    dafilt_word #(.W(16), .ADDR_W(ADDR_W), .ADR(MAC_LO_A)) u_mac_lo (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data[15:0]), .wr_be(wr_be[1:0]), .q(mac_lo_q)
    );

    for (genvar i = 0; i < UC_WORDS; i++) begin : g_uc
        dafilt_word #(.W(REG_W), .ADDR_W(ADDR_W), .ADR(ADDR_W'(ADR_UC_BASE + i))) u_w (
            .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
            .wr_data(wr_data), .wr_be(wr_be), .q(uc_w[i])
        );
    end

    for (genvar i = 0; i < MC_WORDS; i++) begin : g_mc
        dafilt_word #(.W(REG_W), .ADDR_W(ADDR_W), .ADR(ADDR_W'(ADR_SM_BASE + i))) u_sm (
            .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
            .wr_data(wr_data), .wr_be(wr_be), .q(sm_w[i])
        );
        dafilt_word #(.W(REG_W), .ADDR_W(ADDR_W), .ADR(ADDR_W'(ADR_OM_BASE + i))) u_om (
            .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
            .wr_data(wr_data), .wr_be(wr_be), .q(om_w[i])
        );
    end

    // Registered read port.
    logic [REG_W-1:0] rd_next;
    always_comb begin
        rd_next = '0;
        if (rd_addr == MAC_HI_A) begin
            rd_next = mac_hi_q;
        end else if (rd_addr == MAC_LO_A) begin
            rd_next = {16'h0000, mac_lo_q};
        end else if (rd_addr[ADDR_W-1:UCW_W] == UC_TAG) begin
            rd_next = uc_w[rd_addr[UCW_W-1:0]];
        end else if (rd_addr[ADDR_W-1:MCW_W] == SM_TAG) begin
            rd_next = sm_w[rd_addr[MCW_W-1:0]];
        end else if (rd_addr[ADDR_W-1:MCW_W] == OM_TAG) begin
            rd_next = om_w[rd_addr[MCW_W-1:0]];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else begin
            rd_data <= rd_next;
        end
    end

    // Lookup side: pick word by index/4, lane by index%4.
    logic [REG_W-1:0] uc_sel, sm_sel, om_sel;
    assign uc_sel = uc_w[uc_idx[UCI_W-1:2]];
    assign sm_sel = sm_w[sm_idx[MCI_W-1:2]];
    assign om_sel = om_w[om_idx[MCI_W-1:2]];

    assign uc_entry = uc_sel[{uc_idx[1:0], 3'b000} +: 4];
    assign sm_entry = sm_sel[{sm_idx[1:0], 3'b000} +: 4];
    assign om_entry = om_sel[{om_idx[1:0], 3'b000} +: 4];

    assign mac_upper = {mac_hi_q, mac_lo_q[15:UCI_W]};
endmodule

// File: rtl/dafilt_classify.sv
module dafilt_classify
    import dafilt_pkg::*;
#(
    parameter int UCI_W = 4,
    parameter int MCI_W = 8
) (
    input  logic [MAC_W-1:0]       da,
    input  logic [MAC_W-UCI_W-1:0] mac_upper,
    output da_class_e              cls,
    output logic                   uc_match,
    output logic [UCI_W-1:0]       uc_idx,
    output logic [MCI_W-1:0]       sm_idx,
    output logic [MCI_W-1:0]       om_idx
);
    logic group_bit;
    logic in_special;

    assign group_bit  = da[40];
    assign in_special = (da[MAC_W-1:MCI_W] == SPECIAL_BASE[MAC_W-1:MCI_W]);

    always_comb begin
        if (!group_bit) begin
            cls = CLS_UNICAST;
        end else if (in_special) begin
            cls = CLS_SPECIAL;
        end else begin
            cls = CLS_OTHER;
        end
    end

    assign uc_match = (da[MAC_W-1:UCI_W] == mac_upper);
    assign uc_idx   = da[UCI_W-1:0];
    assign sm_idx   = da[MCI_W-1:0];
    assign om_idx   = MCI_W'(addr_hash(da));
endmodule

// File: rtl/dafilt_top.sv
module dafilt_top
    import dafilt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int UC_WORDS = 4,
    parameter int MC_WORDS = 64,
    parameter int QUEUE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [3:0]        wr_be,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    input  logic              da_valid,
    input  logic [MAC_W-1:0]  da,
    output logic              res_valid,
    output logic              res_accept,
    output logic [QUEUE_W-1:0] res_queue
);
    localparam int UCI_W = $clog2(UC_WORDS) + 2;
    localparam int MCI_W = $clog2(MC_WORDS) + 2;

    da_class_e              cls;
    logic                   uc_match;
    logic [UCI_W-1:0]       uc_idx;
    logic [MCI_W-1:0]       sm_idx, om_idx;
    logic [3:0]             uc_entry, sm_entry, om_entry;
    logic [MAC_W-UCI_W-1:0] mac_upper;

    dafilt_regs #(.ADDR_W(ADDR_W), .UC_WORDS(UC_WORDS), .MC_WORDS(MC_WORDS)) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .uc_idx(uc_idx), .sm_idx(sm_idx), .om_idx(om_idx),
        .uc_entry(uc_entry), .sm_entry(sm_entry), .om_entry(om_entry),
        .mac_upper(mac_upper)
    );

    dafilt_classify #(.UCI_W(UCI_W), .MCI_W(MCI_W)) u_cls (
        .da(da), .mac_upper(mac_upper), .cls(cls), .uc_match(uc_match),
        .uc_idx(uc_idx), .sm_idx(sm_idx), .om_idx(om_idx)
    );

    // Verdict from the selected entry: bit 0 accept, bits 3:1 queue.
    logic [3:0]         entry;
    logic               acc_c;
    logic [QUEUE_W-1:0] que_c;

    always_comb begin
        unique case (cls)
            CLS_UNICAST: begin
                entry = uc_entry;
                acc_c = uc_entry[0] && uc_match;
            end
            CLS_SPECIAL: begin
                entry = sm_entry;
                acc_c = sm_entry[0];
            end
            default: begin
                entry = om_entry;
                acc_c = om_entry[0];
            end
        endcase
        que_c = acc_c ? QUEUE_W'(entry[3:1]) : '0;
    end

    // Result sequencer.
    res_state_e state_q, state_nx;

    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_nx = da_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_nx = da_valid ? ST_RESULT : ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_accept <= 1'b0;
            res_queue  <= '0;
        end else if (da_valid) begin
            res_accept <= acc_c;
            res_queue  <= que_c;
        end else begin
            res_accept <= 1'b0;
            res_queue  <= '0;
        end
    end

    assign res_valid = (state_q == ST_RESULT);
endmodule

// File: rtl/dafilt_checker.sv
module dafilt_checker #(
    parameter int QUEUE_W = 3,
    parameter int UP_W = 44
) (
    input logic               clk,
    input logic               rst,
    input logic               da_valid,
    input logic [47:0]        da,
    input logic               res_valid,
    input logic               res_accept,
    input logic [QUEUE_W-1:0] res_queue,
    input logic [UP_W-1:0]    mac_upper
);
    AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        da_valid |=> res_valid); // R9

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(da_valid)); // R9

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> (!res_accept && res_queue == '0)); // R9

    AST_REJECT_QUEUE: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_accept) |-> res_queue == '0); // R10

    AST_UNICAST_MATCH: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_accept && !$past(da[40]))
            |-> ($past(da[47:48-UP_W]) == $past(mac_upper))); // R6
endmodule

bind dafilt_top dafilt_checker #(.QUEUE_W(QUEUE_W), .UP_W(48 - UCI_W)) u_chk (
    .clk(clk), .rst(rst), .da_valid(da_valid), .da(da),
    .res_valid(res_valid), .res_accept(res_accept), .res_queue(res_queue),
    .mac_upper(mac_upper)
);

// File: tb/dafilt_top_tb_top.sv
module dafilt_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG = 50000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_be = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        da_valid = 1'b0;
    logic [47:0] da = '0;
    logic        res_valid;
    logic        res_accept;
    logic [2:0]  res_queue;

    always #(CLK_PERIOD/2) clk = ~clk;

    dafilt_top dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_be(wr_be), .rd_addr(rd_addr), .rd_data(rd_data), .da_valid(da_valid),
        .da(da), .res_valid(res_valid), .res_accept(res_accept), .res_queue(res_queue)
    );

    int n_chk = 0;
    int n_bad = 0;

    // Reference state built from the requirements.
    logic [47:0] mac_m = '0;
    logic [7:0]  uc_m [16];
    logic [7:0]  sm_m [256];
    logic [7:0]  om_m [256];

    typedef struct packed {
        logic [3:0] val;
        logic [7:0] tag;
    } exp_t;
    exp_t exp_q[$];
    string tag_name [4] = '{"R6", "R7", "R8", "R11"};

    task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_hash(input logic [47:0] a);
        logic [8:0] r;
        r = '0;
        for (int k = 47; k >= 0; k--) begin
            r = {r[7:0], 1'b0};
            if (r[8] ^ a[k]) r[7:0] = r[7:0] ^ 8'h07;
            r[8] = 1'b0;
        end
        return r[7:0];
    endfunction

    function automatic logic [3:0] ref_verdict(input logic [47:0] a);
        logic [7:0] e;
        logic acc;
        if (!a[40]) begin
            e = uc_m[a[3:0]];
            acc = e[0] && (a[47:4] == mac_m[47:4]);
        end else if (a[47:8] == 40'h01005E0000) begin
            e = sm_m[a[7:0]];
            acc = e[0];
        end else begin
            e = om_m[ref_hash(a)];
            acc = e[0];
        end
        return acc ? {1'b1, e[3:1]} : 4'b0000;
    endfunction

    function automatic void ref_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        for (int l = 0; l < 4; l++) begin
            if (be[l]) begin
                if (a == 8'h00) mac_m[16 + 8*l +: 8] = d[8*l +: 8];
                else if (a == 8'h01 && l < 2) mac_m[8*l +: 8] = d[8*l +: 8];
                else if (a >= 8'h04 && a <= 8'h07) uc_m[(a - 8'h04)*4 + l] = d[8*l +: 8];
                else if (a >= 8'h40 && a <= 8'h7F) sm_m[(a - 8'h40)*4 + l] = d[8*l +: 8];
                else if (a >= 8'h80 && a <= 8'hBF) om_m[(a - 8'h80)*4 + l] = d[8*l +: 8];
            end
        end
    endfunction

    function automatic logic [31:0] ref_read(input logic [7:0] a);
        logic [31:0] w;
        w = '0;
        if (a == 8'h00) w = mac_m[47:16];
        else if (a == 8'h01) w = {16'h0, mac_m[15:0]};
        else begin
            for (int l = 0; l < 4; l++) begin
                if (a >= 8'h04 && a <= 8'h07) w[8*l +: 8] = uc_m[(a - 8'h04)*4 + l];
                else if (a >= 8'h40 && a <= 8'h7F) w[8*l +: 8] = sm_m[(a - 8'h40)*4 + l];
                else if (a >= 8'h80 && a <= 8'hBF) w[8*l +: 8] = om_m[(a - 8'h80)*4 + l];
            end
        end
        return w;
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en = 1'b0;
            da_valid = 1'b0;
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        da_valid = 1'b0;
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
        ref_write(a, d, be);
    endtask

    task automatic reg_read_chk(input logic [7:0] a, input string req);
        logic [31:0] e;
        @(negedge clk);
        wr_en = 1'b0; da_valid = 1'b0;
        rd_addr = a;
        e = ref_read(a);
        @(negedge clk);
        chk(rd_data === e, req, 48'(rd_data), 48'(e));
    endtask

    // Driver: present one address and queue its expected verdict.
    task automatic lookup(input logic [47:0] a, input int tg);
        @(negedge clk);
        wr_en = 1'b0;
        da_valid = 1'b1; da = a;
        exp_q.push_back('{val: ref_verdict(a), tag: 8'(tg)});
    endtask

    // Lookup and write in the same cycle: verdict uses the old tables.
    task automatic lookup_and_write(input logic [47:0] a, input logic [7:0] wa,
                                    input logic [31:0] wd, input logic [3:0] wb);
        @(negedge clk);
        da_valid = 1'b1; da = a;
        wr_en = 1'b1; wr_addr = wa; wr_data = wd; wr_be = wb;
        exp_q.push_back('{val: ref_verdict(a), tag: 8'd3});
        ref_write(wa, wd, wb);
    endtask

    // Monitor: pops one expected item per result.
    int n_results = 0;
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            exp_t it;
            n_results++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9", 48'(res_valid), 48'd0);
            end else begin
                it = exp_q.pop_front();
                chk({res_accept, res_queue} === it.val, tag_name[it.tag],
                    48'({res_accept, res_queue}), 48'(it.val));
            end
        end
    end

    int cycles = 0;
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    logic [47:0] own;
    logic [7:0]  hidx;
    initial begin
        for (int i = 0; i < 16; i++) uc_m[i] = '0;
        for (int i = 0; i < 256; i++) begin
            sm_m[i] = '0;
            om_m[i] = '0;
        end
        own = 48'h005043123456;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(res_valid === 1'b0 && res_accept === 1'b0 && res_queue === 3'd0, "R1",
            48'({res_valid, res_accept, res_queue}), 48'd0);
        reg_read_chk(8'h00, "R1");
        reg_read_chk(8'h05, "R1");
        lookup(48'h000000000000, 0); // R1: empty tables reject
        lookup(48'hFFFFFFFFFFFF, 2);
        idle(2);

        // R3: station address layout
        reg_write(8'h00, own[47:16], 4'hF);
        reg_write(8'h01, {16'hBEEF, own[15:0]}, 4'hF);
        reg_read_chk(8'h00, "R3");
        reg_read_chk(8'h01, "R3");

        // R4/R5: nibble 6 -> word 0x05 lane 2, accept with queue 5
        reg_write(8'h05, 32'h000B0000, 4'b0100);
        reg_read_chk(8'h05, "R4");
        lookup(own, 0);                          // R6 accept q5
        lookup(own ^ 48'h000000000100, 0);       // R6 upper mismatch
        lookup({own[47:4], 4'h7}, 0);            // R4 neighbour nibble empty
        idle(2);

        // R2: byte-enable write beside a live entry
        reg_write(8'h05, 32'hFFFFFFFF, 4'b0010);
        reg_read_chk(8'h05, "R2");
        lookup({own[47:4], 4'h5}, 0);            // R5 queue 7
        idle(2);

        // R7: special multicast, index 0x23 -> word 0x48 lane 3, queue 3
        reg_write(8'h48, 32'h07000000, 4'b1000);
        lookup(48'h01005E000023, 1);
        lookup(48'h01005E000022, 1);
        idle(2);

        // R8: hashed multicast
        hidx = ref_hash(48'h01005E010203);
        reg_write(8'h80 + {2'b00, hidx[7:2]}, 32'h05 << (8 * hidx[1:0]), 4'b0001 << hidx[1:0]);
        lookup(48'h01005E010203, 2);
        lookup(48'h333300000001, 2);
        idle(2);

        // R11: write during lookup, then follow-up lookup
        lookup_and_write(own, 8'h05, 32'h00000000, 4'b0100);
        lookup(own, 3);
        idle(2);

        // R9: back-to-back strobes, then quiet outputs
        lookup(own, 0);
        lookup(48'h01005E000023, 1);
        lookup({own[47:4], 4'h5}, 0);
        idle(2);
        chk(res_valid === 1'b0 && res_accept === 1'b0 && res_queue === 3'd0, "R9",
            48'({res_valid, res_accept, res_queue}), 48'd0);
        chk(exp_q.size() == 0, "R9", 48'(exp_q.size()), 48'd0);
        chk(n_results == 15, "R9", 48'(n_results), 48'd15);

        // R12: unmapped address
        reg_write(8'h20, 32'hFFFFFFFF, 4'hF);
        reg_read_chk(8'h20, "R12");
        reg_read_chk(8'h03, "R12");
        reg_read_chk(8'h05, "R12");

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule